// File: doc/BRIEF.md
# Delay-Slot Branch Resolver

This block settles branch outcomes for an in-order core whose branches may carry one delay slot. The decode stage presents a branch class, the raw instruction word, the value of ra, operand B and the PC of the branch. The block evaluates the condition, forms the target and captures the outcome. It then counts retire strobes until the branch, and its slot instruction if one was requested, have left the pipeline. Only then does it pulse a redirect toward fetch, together with the mode-restore code of a return-type branch.

Link writes, break events and illegal-condition flags are reported one cycle after a branch is accepted. While a branch is still pending, new branch requests are ignored. A delay-slot flag shows when the instruction now in flight is a slot instruction.

Top module: `br_resolve`

## Requirements
- R1: A conditional branch (class 1) reads its condition from instruction bits 23..21 and compares ra, as a signed value, with zero: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal.
- R2: The delay request is instruction bit 25 for class 1 and bit 20 for an unconditional branch (class 2); a return (class 3) always has it. A delayed branch waits for two retire strobes and any other branch for one. A taken branch raises redirect_valid for one cycle after the clock edge that samples the last of those strobes.
- R3: The target is pc plus operand B for class 1, and for class 2 with bit 19 clear. It is operand B itself for class 2 with bit 19 set, and ra plus operand B for class 3.
- R4: A class 2 branch with bit 18 set pulses link_we for one cycle after acceptance, with link_rd equal to instruction bits 25..21 and link_val equal to the branch PC.
- R5: A class 1 branch whose condition fails produces no redirect pulse, and the block is free again once the branch retires.
- R6: For a delayed branch, slot_active is high from the retire of the branch until the retire of its slot instruction, and low otherwise.
- R7: A class 2 branch with bits 19 and 18 set, no immediate prefix, and operand B equal to 8 or 0x18 pulses brk for one cycle after acceptance.
- R8: Condition codes 6 and 7 pulse illegal for one cycle after acceptance, and the branch is treated as not taken.
- R9: A branch request presented while an earlier branch is pending is ignored: it produces no link write, and it changes neither the target nor the timing of the earlier branch.
- R10: A return chooses its mode code from bit 21 (interrupt, code 1), else bit 22 (break, code 2), else bit 23 (exception, code 3), and otherwise code 0. The code appears on ret_mode together with the redirect pulse.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_class_i | input | 2 | 0 none, 1 conditional, 2 unconditional, 3 return |
| instr_i | input | 32 | Raw branch instruction word |
| ra_i | input | XLEN | Value of register ra |
| opb_i | input | XLEN | Operand B (register or extended immediate) |
| pc_i | input | XLEN | PC of the branch |
| prefix_i | input | 1 | Branch carried an immediate prefix |
| retire_i | input | 1 | One instruction retires this cycle |
| redirect_valid_o | output | 1 | One-cycle redirect pulse |
| redirect_target_o | output | XLEN | Redirect address |
| ret_mode_o | output | 2 | Return mode code with the redirect |
| slot_active_o | output | 1 | Slot instruction in flight |
| link_we_o | output | 1 | Link write pulse |
| link_rd_o | output | 5 | Link destination index |
| link_val_o | output | XLEN | Link value (branch PC) |
| brk_o | output | 1 | Break event pulse |
| illegal_o | output | 1 | Illegal condition pulse |

## Verification
Link, break and illegal results are registered at the edge that accepts the branch, so they are due in the cycle that follows it. The redirect, its target and the mode code are due in the cycle after the edge that samples the final retire strobe. slot_active is due right after the branch's own retire edge. The bench changes inputs on falling edges and reads outputs at the next falling edge, so each sample lands in exactly the cycle where the result is due.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_COND = 2'd1,
        BC_JUMP = 2'd2,
        BC_RET  = 2'd3
    } br_class_e;

    typedef enum logic [1:0] {
        RM_SUB = 2'd0,
        RM_INT = 2'd1,
        RM_BRK = 2'd2,
        RM_EXC = 2'd3
    } ret_mode_e;

    // instruction field positions
    localparam int CC_LSB      = 21;
    localparam int COND_DLY    = 25;
    localparam int JMP_DLY     = 20;
    localparam int JMP_ABS     = 19;
    localparam int JMP_LNK     = 18;
    localparam int RET_INT_BIT = 21;
    localparam int RET_BRK_BIT = 22;
    localparam int RET_EXC_BIT = 23;
    localparam int RD_LSB      = 21;

    typedef struct packed {
        logic      taken;
        logic      delayed;
        logic      link;
        logic      brk;
        logic      illegal;
        ret_mode_e mode;
    } br_flags_t;

    // returns {legal, hit}
    function automatic logic [1:0] cond_eval(input logic [2:0] cc,
                                             input logic neg, input logic zero);
        logic [1:0] r;
        case (cc)
            3'd0:    r = {1'b1, zero};
            3'd1:    r = {1'b1, !zero};
            3'd2:    r = {1'b1, neg};
            3'd3:    r = {1'b1, neg || zero};
            3'd4:    r = {1'b1, !neg && !zero};
            3'd5:    r = {1'b1, !neg};
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RW   = 5
) (
    input  br_class_e         cls,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   ra,
    input  logic [XLEN-1:0]   opb,
    input  logic [XLEN-1:0]   pc,
    input  logic              prefix,
    output br_flags_t         flags,
    output logic [XLEN-1:0]   target,
    output logic [RW-1:0]     rd
);
    localparam logic [XLEN-1:0] BRK_A = XLEN'(8);
    localparam logic [XLEN-1:0] BRK_B = XLEN'(24);

    logic [1:0] cres;

    assign cres = cond_eval(instr[CC_LSB +: 3], ra[XLEN-1], ra == '0);
    assign rd   = instr[RD_LSB +: RW];

    always_comb begin
        flags  = '0;
        target = pc + opb;
        case (cls)
            BC_COND: begin
                flags.taken   = cres[1] && cres[0];
                flags.illegal = !cres[1];
                flags.delayed = instr[COND_DLY];
            end
            BC_JUMP: begin
                flags.taken   = 1'b1;
                flags.delayed = instr[JMP_DLY];
                flags.link    = instr[JMP_LNK];
                if (instr[JMP_ABS]) target = opb;
                flags.brk     = instr[JMP_ABS] && instr[JMP_LNK] && !prefix
                                && (opb == BRK_A || opb == BRK_B);
            end
            BC_RET: begin
                flags.taken   = 1'b1;
                flags.delayed = 1'b1;
                target        = ra + opb;
                if (instr[RET_INT_BIT])      flags.mode = RM_INT;
                else if (instr[RET_BRK_BIT]) flags.mode = RM_BRK;
                else if (instr[RET_EXC_BIT]) flags.mode = RM_EXC;
                else                         flags.mode = RM_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br_delay_ctr.sv
module br_delay_ctr
    import br_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            accept,
    input  br_flags_t       flags,
    input  logic [XLEN-1:0] target,
    input  logic            retire,
    output logic            busy,
    output logic            slot_active,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_target,
    output ret_mode_e       redir_mode
);
    localparam logic [CW-1:0] LD_DLY = CW'(2);
    localparam logic [CW-1:0] LD_ONE = CW'(1);

    logic [CW-1:0]   cnt, cnt_eff, cnt_n;
    logic            p_taken, p_dly, tk_eff, dly_eff, step, fire;
    logic [XLEN-1:0] p_tgt, tgt_eff;
    ret_mode_e       p_mode, mode_eff;

    always_comb begin
        cnt_eff  = accept ? (flags.delayed ? LD_DLY : LD_ONE) : cnt;
        tk_eff   = accept ? flags.taken   : p_taken;
        dly_eff  = accept ? flags.delayed : p_dly;
        tgt_eff  = accept ? target        : p_tgt;
        mode_eff = accept ? flags.mode    : p_mode;
        step     = retire && (cnt_eff != '0);
        cnt_n    = step ? cnt_eff - LD_ONE : cnt_eff;
        fire     = step && (cnt_eff == LD_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            p_taken      <= 1'b0;
            p_dly        <= 1'b0;
            p_tgt        <= '0;
            p_mode       <= RM_SUB;
            redir_valid  <= 1'b0;
            redir_target <= '0;
            redir_mode   <= RM_SUB;
        end else begin
            cnt         <= cnt_n;
            p_taken     <= tk_eff;
            p_dly       <= dly_eff;
            p_tgt       <= tgt_eff;
            p_mode      <= mode_eff;
            redir_valid <= fire && tk_eff;
            redir_mode  <= (fire && tk_eff) ? mode_eff : RM_SUB;
            if (fire && tk_eff) redir_target <= tgt_eff;
        end
    end

    assign busy        = cnt != '0;
    assign slot_active = (cnt == LD_ONE) && p_dly;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LD_DLY);

    p_slot_after_branch_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt == LD_DLY && retire) |=> slot_active);

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (req && busy && !retire) |=> $stable(cnt));
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RW   = 5,
    parameter int CW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      br_class_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] ra_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            prefix_i,
    input  logic            retire_i,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_target_o,
    output logic [1:0]      ret_mode_o,
    output logic            slot_active_o,
    output logic            link_we_o,
    output logic [RW-1:0]   link_rd_o,
    output logic [XLEN-1:0] link_val_o,
    output logic            brk_o,
    output logic            illegal_o
);
    br_class_e       cls;
    br_flags_t       flags;
    logic [XLEN-1:0] target;
    logic [RW-1:0]   rd;
    logic            req, busy, accept;
    ret_mode_e       rmode;

    assign cls    = br_class_e'(br_class_i);
    assign req    = cls != BC_NONE;
    assign accept = req && !busy;

    br_decode #(.XLEN(XLEN), .RW(RW)) u_dec (
        .cls(cls), .instr(instr_i), .ra(ra_i), .opb(opb_i), .pc(pc_i),
        .prefix(prefix_i), .flags(flags), .target(target), .rd(rd)
    );

    br_delay_ctr #(.XLEN(XLEN), .CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .req(req), .accept(accept), .flags(flags),
        .target(target), .retire(retire_i), .busy(busy),
        .slot_active(slot_active_o), .redir_valid(redirect_valid_o),
        .redir_target(redirect_target_o), .redir_mode(rmode)
    );

    assign ret_mode_o = rmode;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_we_o  <= 1'b0;
            link_rd_o  <= '0;
            link_val_o <= '0;
            brk_o      <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            link_we_o <= accept && flags.link;
            brk_o     <= accept && flags.brk;
            illegal_o <= accept && flags.illegal;
            if (accept && flags.link) begin
                link_rd_o  <= rd;
                link_val_o <= pc_i;
            end
        end
    end

    p_redir_needs_retire_r2: assert property (@(posedge clk) disable iff (rst)
        redirect_valid_o |-> $past(retire_i));

    p_brk_with_link_r7: assert property (@(posedge clk) disable iff (rst)
        brk_o |-> link_we_o);

    p_illegal_untaken_r8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !redirect_valid_o);
endmodule

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      cls = 2'd0;
    logic [31:0]     ins = '0;
    logic [XLEN-1:0] ra = '0, ob = '0, pc = '0;
    logic            pfx = 1'b0, ret = 1'b0;
    logic            rv, slot, lwe, brk, ill;
    logic [XLEN-1:0] rtgt, lval;
    logic [1:0]      rmode;
    logic [4:0]      lrd;
    int total = 0, fails = 0;

    always #2.5 clk = ~clk;

    br_resolve u0 (
        .clk(clk), .rst(rst), .br_class_i(cls), .instr_i(ins), .ra_i(ra),
        .opb_i(ob), .pc_i(pc), .prefix_i(pfx), .retire_i(ret),
        .redirect_valid_o(rv), .redirect_target_o(rtgt), .ret_mode_o(rmode),
        .slot_active_o(slot), .link_we_o(lwe), .link_rd_o(lrd),
        .link_val_o(lval), .brk_o(brk), .illegal_o(ill)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_br(input logic [1:0] c, input logic [31:0] in, input logic [31:0] ra_v,
                          input logic [31:0] ob_v, input logic [31:0] pc_v, input logic pf,
                          input string tag);
        logic dly, tk, legal, lk, bk;
        logic [31:0] tgt;
        logic [1:0] md;
        logic signed [31:0] s;
        s = ra_v;
        dly = (c == 2'd1) ? in[25] : (c == 2'd2) ? in[20] : 1'b1;
        legal = 1'b1; tk = 1'b1;
        if (c == 2'd1) begin
            case (in[23:21])
                3'd0: tk = (s == 0);
                3'd1: tk = (s != 0);
                3'd2: tk = (s < 0);
                3'd3: tk = (s <= 0);
                3'd4: tk = (s > 0);
                3'd5: tk = (s >= 0);
                default: begin tk = 1'b0; legal = 1'b0; end
            endcase
        end
        tgt = (c == 2'd3) ? ra_v + ob_v : (c == 2'd2 && in[19]) ? ob_v : pc_v + ob_v;
        lk = (c == 2'd2) && in[18];
        bk = (c == 2'd2) && in[19] && in[18] && !pf && (ob_v == 32'd8 || ob_v == 32'h18);
        md = (c != 2'd3) ? 2'd0 : in[21] ? 2'd1 : in[22] ? 2'd2 : in[23] ? 2'd3 : 2'd0;
        @(negedge clk);
        cls = c; ins = in; ra = ra_v; ob = ob_v; pc = pc_v; pfx = pf;
        @(negedge clk);
        cls = 2'd0;
        chk(lwe == lk, "R4 link_we", 32'(lwe), 32'(lk));
        if (lk) begin
            chk(lrd == in[25:21], "R4 link_rd", 32'(lrd), 32'(in[25:21]));
            chk(lval == pc_v, "R4 link_val", lval, pc_v);
        end
        chk(brk == bk, "R7 brk", 32'(brk), 32'(bk));
        chk(ill == !legal, "R8 illegal", 32'(ill), 32'(!legal));
        if (dly) begin
            ret = 1'b1;
            @(negedge clk);
            ret = 1'b0;
            chk(slot == 1'b1, "R6 slot_active", 32'(slot), 32'd1);
            chk(rv == 1'b0, "R2 early redirect", 32'(rv), 32'd0);
        end
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
        chk(rv == tk, tag, 32'(rv), 32'(tk));
        if (tk) chk(rtgt == tgt, "R3 target", rtgt, tgt);
        if (tk) chk(rmode == md, "R10 ret_mode", 32'(rmode), 32'(md));
        chk(slot == 1'b0, "R6 slot clear", 32'(slot), 32'd0);
        @(negedge clk);
        chk(rv == 1'b0, "R2 single pulse", 32'(rv), 32'd0);
    endtask

    initial begin
        #(5 * 200000);
        fails++; total++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] ravals [5];
        ravals[0] = 32'hFFFF_FFFB; ravals[1] = 32'hFFFF_FFFF; ravals[2] = 32'd0;
        ravals[3] = 32'd1; ravals[4] = 32'd7;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({rv, slot, lwe, brk, ill, rmode} == '0, "R11 reset outputs", 32'({rv, slot, lwe, brk, ill, rmode}), 32'd0);
        chk(rtgt == '0 && lval == '0, "R11 reset data", rtgt | lval, 32'd0);
        // R1 R5 R8 conditional sweep
        for (int cc = 0; cc < 8; cc++)
            for (int r = 0; r < 5; r++)
                for (int d = 0; d < 2; d++)
                    run_br(2'd1, (32'(d) << 25) | (32'(cc) << 21), ravals[r], 32'h20, 32'h400 + 32'(cc * 16), 1'b0, "R1 R5 cond redirect");
        // R3 R4 unconditional combos
        for (int k = 0; k < 8; k++)
            run_br(2'd2, (32'(k + 3) << 21) | (32'(k) << 18), 32'd0, 32'h40, 32'h1000, 1'b0, "R2 R3 jump redirect");
        // R7 break cases
        run_br(2'd2, 32'h000C_0000, 32'd0, 32'd8, 32'h200, 1'b0, "R7 brk 8");
        run_br(2'd2, 32'h000C_0000, 32'd0, 32'h18, 32'h200, 1'b0, "R7 brk 18");
        run_br(2'd2, 32'h000C_0000, 32'd0, 32'd8, 32'h200, 1'b1, "R7 prefixed");
        run_br(2'd2, 32'h000C_0000, 32'd0, 32'h10, 32'h200, 1'b0, "R7 other addr");
        run_br(2'd2, 32'h0004_0000, 32'd0, 32'd8, 32'h200, 1'b0, "R7 relative");
        // R10 return variants
        for (int m = 0; m < 8; m++)
            run_br(2'd3, 32'(m) << 21, 32'h3000 + 32'(m), 32'h8, 32'h500, 1'b0, "R10 return redirect");
        // R9: second request while pending is ignored
        @(negedge clk);
        cls = 2'd2; ins = 32'h0010_0000; ob = 32'h80; pc = 32'h700; pfx = 1'b0;
        @(negedge clk);
        cls = 2'd2; ins = 32'h03CC_0000; ob = 32'h999; pc = 32'h900;
        @(negedge clk);
        cls = 2'd0;
        chk(lwe == 1'b0, "R9 ignored link", 32'(lwe), 32'd0);
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
        chk(rv == 1'b0 && slot == 1'b1, "R9 timing kept", 32'({rv, slot}), 32'b01);
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
        chk(rv == 1'b1, "R9 redirect", 32'(rv), 32'd1);
        chk(rtgt == 32'h780, "R9 target kept", rtgt, 32'h780);
        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule